// File: doc/BRIEF.md
# Buffered Input Capture Unit

This block timestamps edges on external pins against its own 16-bit free-running counter. There are four capture channels, called A, B, C and D, each with a pin, a capture register and a capture flag. Each channel has one edge-select bit in the control register. A pin edge passes through a synchronizer and then loads the counter value into the channel's capture register. The same edge raises the channel's flag.

Channels are grouped in pairs: A with C, and B with D. When a pair's buffer mode is on, the second register of the pair stops being an independent channel and becomes a one-deep history behind the first. Each capture on the first pin loads the counter into the first register. In the same clock, the value the first register held moves into the second. In buffer mode the pin of the second channel is ignored. The pair's two edge-select bits then pick the capture edges of the first pin: one edge when the bits agree, both edges when they differ.

A simple register port gives software access to the block. Writes and reads are single-cycle strobes with no wait states. Read data is a combinational function of the address, so the bus never stalls and needs no back-pressure. The pins, the flags and the counter value are plain signals with no handshake.

Top module: `icap_bank`

## Requirements
- R1: The counter resets to 0 and increases by one on every clock, wrapping at 16 bits. It can be read at address 6, and writes to address 6 are ignored.
- R2: With buffer mode off, each channel i captures on its own pin. Control bit i = 1 selects the rising edge and 0 selects the falling edge. Channels A..D are bits 0..3 and pins 0..3.
- R2 (timing): When a pin changes before clock edge k, the register is loaded at edge k+2. It takes the counter value that was present just before edge k+2.
- R3: Control bit 4 turns on buffer mode for pair A/C. On each capture on pin A, register A takes the counter value and register C takes the previous value of register A, both in the same clock.
- R4: Control bit 5 turns on buffer mode for pair B/D in the same way. Pin B loads register B, and the old value of register B moves into register D.
- R5: In buffer mode, if the edge-select bits of the pair differ (bit 0 versus bit 2, or bit 1 versus bit 3), the first pin of the pair captures on both rising and falling edges.
- R6: In buffer mode, if the pair's edge-select bits are equal, the first pin captures only on the edge that both bits select.
- R7: In buffer mode, pins C and D have no effect on any register or flag. Register C or D changes only through the shift of its pair or through a bus write.
- R8: The flag register is at address 6's neighbour, address 5, with bits 0..3 for channels A..D. A capture into a channel's register sets that channel's flag. A capture shifted in as buffer history does not count.
- R8 (clearing): Reading address 5 arms every flag that is 1 at that moment. Writing address 5 clears each armed flag whose written bit is 0. The write then disarms all flags.
- R8 (no effect): Writing 0 to a flag that is not armed leaves it set. Writing 1 leaves a flag unchanged. A capture in the same cycle as a clear leaves the flag set.
- R9: A capture wins over a bus write to the same register in the same clock. This includes a write to the buffer register in the clock in which it receives a shifted value.
- R10: Addresses 0..3 read and write capture registers A..D. Address 4 is the control register: bits 3..0 are edge selects and bits 5..4 are buffer enables, and it reads back zero-extended. Unused addresses read 0.
- R11: After reset, all capture registers, the control register, the flags and the counter read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; used only to arm flags at address 5 |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| cap_pin | input | 4 | Capture pins A..D, asynchronous |
| cap_flag | output | 4 | Capture flags A..D |
| count | output | 16 | Free-running counter value |

## Verification
The bench runs random pin toggles on all four pins. It does this with buffer mode off, with matched edge selects, and with mismatched edge selects. The first run separates per-channel edge polarity. The second shows that a falling edge does not capture when both bits select rising. The third shows that both edges capture only when the bits differ. A run that toggles only pins C and D in buffer mode shows that those pins have no path into a register or flag. Random flag reads and writes, mixed with captures, separate armed clears from unarmed ones. Timed bus writes placed exactly on a capture clock show whether the capture or the write wins, for both the primary and the buffer register.

// File: rtl/icap_pkg.sv
package icap_pkg;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;

  function automatic logic pick_edge(edge_t e, logic rising);
    return rising ? e.rise : e.fall;
  endfunction

endpackage

// File: rtl/icap_sync_edge.sv
module icap_sync_edge
  import icap_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pin,
  output edge_t ev
);

  // sh[STAGES-1] is the synchronized level, sh[STAGES] the level one clock earlier
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], pin};
  end

  assign ev.rise = sh[STAGES-1] & ~sh[STAGES];
  assign ev.fall = ~sh[STAGES-1] & sh[STAGES];

endmodule

// File: rtl/icap_pair.sv
module icap_pair
  import icap_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  edge_t        ev_p,
  input  edge_t        ev_s,
  input  logic         es_p,
  input  logic         es_s,
  input  logic         buf_en,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] wdata,
  input  logic         wr_p,
  input  logic         wr_s,
  output logic [W-1:0] reg_p,
  output logic [W-1:0] reg_s,
  output logic         trig_p,
  output logic         trig_s
);

  logic dual;

  always_comb begin
    dual   = buf_en & (es_p ^ es_s);
    trig_p = dual ? (ev_p.rise | ev_p.fall) : pick_edge(ev_p, es_p);
    trig_s = ~buf_en & pick_edge(ev_s, es_s);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_p <= '0;
    end else if (trig_p) begin
      reg_p <= cnt;
    end else if (wr_p) begin
      reg_p <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_s <= '0;
    end else if (buf_en && trig_p) begin
      reg_s <= reg_p;
    end else if (trig_s) begin
      reg_s <= cnt;
    end else if (wr_s) begin
      reg_s <= wdata;
    end
  end

endmodule

// File: rtl/icap_flags.sv
module icap_flags #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set,
  input  logic           rd_stb,
  input  logic           wr_stb,
  input  logic [NCH-1:0] wbits,
  output logic [NCH-1:0] flag
);

  logic [NCH-1:0] armed;
  logic [NCH-1:0] clr;

  always_comb clr = wr_stb ? (armed & ~wbits) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= '0;
      armed <= '0;
    end else begin
      flag <= (flag & ~clr) | set;
      if (rd_stb)      armed <= flag;
      else if (wr_stb) armed <= '0;
    end
  end

endmodule

// File: rtl/icap_bank.sv
module icap_bank
  import icap_pkg::*;
#(
  parameter  int CNT_W       = 16,
  parameter  int N_PAIR      = 2,
  parameter  int SYNC_STAGES = 2,
  localparam int NCH         = 2 * N_PAIR,
  localparam int ADDR_W      = $clog2(NCH + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [NCH-1:0]    cap_pin,
  output logic [NCH-1:0]    cap_flag,
  output logic [CNT_W-1:0]  count
);

  localparam int CTRL_W = NCH + N_PAIR;
  localparam int A_CTRL = NCH;
  localparam int A_FLAG = NCH + 1;
  localparam int A_CNT  = NCH + 2;

  logic [CNT_W-1:0]  cnt_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [NCH-1:0]    edge_sel;
  logic [N_PAIR-1:0] buf_en;
  logic [NCH-1:0]    wr_cap;
  logic [NCH-1:0]    evt;
  logic              wr_ctrl, wr_flag, rd_flag;
  edge_t             ev [NCH];
  logic [CNT_W-1:0]  cap_q [NCH];
  logic [CNT_W-1:0]  reg_p_w [N_PAIR];
  logic [CNT_W-1:0]  reg_s_w [N_PAIR];
  logic [N_PAIR-1:0] trig_p_w, trig_s_w;

  assign edge_sel = ctrl_q[NCH-1:0];
  assign buf_en   = ctrl_q[CTRL_W-1:NCH];
  assign wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
  assign wr_flag  = bus_wr && (bus_addr == ADDR_W'(A_FLAG));
  assign rd_flag  = bus_rd && (bus_addr == ADDR_W'(A_FLAG));
  assign count    = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    assign wr_cap[ch] = bus_wr && (bus_addr == ADDR_W'(ch));
    icap_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (cap_pin[ch]),
      .ev   (ev[ch])
    );
  end

  for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
    icap_pair #(.W(CNT_W)) u_pair (
      .clk   (clk),
      .rst_n (rst_n),
      .ev_p  (ev[p]),
      .ev_s  (ev[p + N_PAIR]),
      .es_p  (edge_sel[p]),
      .es_s  (edge_sel[p + N_PAIR]),
      .buf_en(buf_en[p]),
      .cnt   (cnt_q),
      .wdata (bus_wdata),
      .wr_p  (wr_cap[p]),
      .wr_s  (wr_cap[p + N_PAIR]),
      .reg_p (reg_p_w[p]),
      .reg_s (reg_s_w[p]),
      .trig_p(trig_p_w[p]),
      .trig_s(trig_s_w[p])
    );
  end

  always_comb begin
    for (int p = 0; p < N_PAIR; p++) begin
      cap_q[p]          = reg_p_w[p];
      cap_q[p + N_PAIR] = reg_s_w[p];
      evt[p]            = trig_p_w[p];
      evt[p + N_PAIR]   = trig_s_w[p];
    end
  end

  icap_flags #(.NCH(NCH)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (evt),
    .rd_stb(rd_flag),
    .wr_stb(wr_flag),
    .wbits (bus_wdata[NCH-1:0]),
    .flag  (cap_flag)
  );

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == ADDR_W'(i)) bus_rdata = cap_q[i];
    end
    if (bus_addr == ADDR_W'(A_CTRL)) bus_rdata = CNT_W'(ctrl_q);
    if (bus_addr == ADDR_W'(A_FLAG)) bus_rdata = CNT_W'(cap_flag);
    if (bus_addr == ADDR_W'(A_CNT))  bus_rdata = cnt_q;
  end

endmodule

// File: rtl/icap_bank_chk.sv
module icap_bank_chk #(
  parameter int CNT_W  = 16,
  parameter int N_PAIR = 2,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  cap_q [2*N_PAIR],
  input logic [2*N_PAIR-1:0] evt,
  input logic [N_PAIR-1:0] buf_en,
  input logic [2*N_PAIR-1:0] cap_flag,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr
);

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> count == $past(count) + 1'b1); // R1

  for (genvar p = 0; p < N_PAIR; p++) begin : g_pc
    AST_BUF_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_en[p] && evt[p]) |=> (cap_q[p + N_PAIR] == $past(cap_q[p]) && cap_q[p] == $past(count))); // R3

    AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_en[p] && !evt[p] && !(bus_wr && bus_addr == ADDR_W'(p + N_PAIR))) |=> $stable(cap_q[p + N_PAIR])); // R7
  end

  for (genvar i = 0; i < 2 * N_PAIR; i++) begin : g_cc
    AST_FLAG_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> cap_flag[i]); // R8

    AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (evt[i] && bus_wr && bus_addr == ADDR_W'(i)) |=> cap_q[i] != $past(cap_q[i]) || cap_q[i] == $past(count)); // R9
  end

endmodule

bind icap_bank icap_bank_chk #(.CNT_W(CNT_W), .N_PAIR(N_PAIR), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .count   (count),
  .cap_q   (cap_q),
  .evt     (evt),
  .buf_en  (buf_en),
  .cap_flag(cap_flag),
  .bus_wr  (bus_wr),
  .bus_addr(bus_addr)
);

// File: tb/icap_bank_bench.sv
module icap_bank_bench;

  localparam int W   = 16;
  localparam int NP  = 2;
  localparam int NCH = 4;
  localparam int AW  = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [W-1:0]  bus_wdata = '0;
  logic [W-1:0]  bus_rdata;
  logic [NCH-1:0] cap_pin = '0;
  logic [NCH-1:0] cap_flag;
  logic [W-1:0]  count;

  always #5 clk = ~clk;

  icap_bank u_icap_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .cap_pin  (cap_pin),
    .cap_flag (cap_flag),
    .count    (count)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  string cur_req = "R11";

  // behavioural reference state
  int             m_cnt;
  int             m_reg [NCH];
  int             m_ctrl;
  bit [NCH-1:0]   m_flag;
  bit [NCH-1:0]   m_armed;
  bit [NCH-1:0]   hist [$];

  function automatic int exp_rdata(int a);
    if (a < NCH) return m_reg[a];
    if (a == 4)  return m_ctrl;
    if (a == 5)  return int'(m_flag);
    if (a == 6)  return m_cnt;
    return 0;
  endfunction

  task automatic check(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_ctrl = 0; m_flag = '0; m_armed = '0;
    for (int i = 0; i < NCH; i++) m_reg[i] = 0;
    hist.delete();
    for (int i = 0; i < 3; i++) hist.push_back('0);
  endtask

  task automatic model_step();
    bit [NCH-1:0] rise, fall, trig;
    int nr [NCH];
    bit bufm, es_p, es_s;
    int s;
    bit [NCH-1:0] clr;
    // hist[0] = pins three edges ago, hist[1] = two edges ago
    for (int i = 0; i < NCH; i++) begin
      rise[i] = hist[1][i] && !hist[0][i];
      fall[i] = !hist[1][i] && hist[0][i];
    end
    trig = '0;
    for (int p = 0; p < NP; p++) begin
      s = p + NP;
      bufm = ((m_ctrl >> (NCH + p)) & 1) != 0;
      es_p = ((m_ctrl >> p) & 1) != 0;
      es_s = ((m_ctrl >> s) & 1) != 0;
      if (bufm) begin
        if (es_p != es_s) trig[p] = rise[p] | fall[p];
        else              trig[p] = es_p ? rise[p] : fall[p];
      end else begin
        trig[p] = es_p ? rise[p] : fall[p];
        trig[s] = es_s ? rise[s] : fall[s];
      end
    end
    for (int i = 0; i < NCH; i++) nr[i] = m_reg[i];
    if (bus_wr && bus_addr < NCH) nr[bus_addr] = int'(bus_wdata);
    for (int p = 0; p < NP; p++) begin
      s = p + NP;
      bufm = ((m_ctrl >> (NCH + p)) & 1) != 0;
      if (bufm && trig[p]) begin
        nr[s] = m_reg[p];
        nr[p] = m_cnt;
      end else begin
        if (trig[p]) nr[p] = m_cnt;
        if (trig[s]) nr[s] = m_cnt;
      end
    end
    clr = (bus_wr && bus_addr == 5) ? (m_armed & ~bus_wdata[NCH-1:0]) : '0;
    if (bus_rd && bus_addr == 5)      m_armed = m_flag;
    else if (bus_wr && bus_addr == 5) m_armed = '0;
    m_flag = (m_flag & ~clr) | trig;
    if (bus_wr && bus_addr == 4) m_ctrl = int'(bus_wdata) & 6'h3f;
    for (int i = 0; i < NCH; i++) m_reg[i] = nr[i];
    m_cnt = (m_cnt + 1) % 65536;
    hist.push_back(cap_pin);
    void'(hist.pop_front());
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else        model_step();
  end

  // compare on every clock, half a period after the edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(cur_req, int'(count), m_cnt, "counter");
      check(cur_req, int'(cap_flag), int'(m_flag), "flags");
      check(cur_req, int'(bus_rdata), exp_rdata(int'(bus_addr)), $sformatf("rdata@%0d", bus_addr));
    end
  end

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(int a, int d);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = W'(d);
    cyc();
    bus_wr = 1'b0;
  endtask

  task automatic rd_flags();
    bus_rd = 1'b1; bus_addr = AW'(5);
    cyc();
    bus_rd = 1'b0;
  endtask

  task automatic run_rand(int n, bit [NCH-1:0] mask);
    int r;
    for (int k = 0; k < n; k++) begin
      if ($urandom % 4 == 0) cap_pin = cap_pin ^ (NCH'($urandom) & mask);
      r = $urandom % 10;
      bus_wr = 1'b0; bus_rd = 1'b0;
      if (r == 6) begin
        bus_rd = 1'b1; bus_addr = AW'(5);
      end else if (r == 7) begin
        bus_wr = 1'b1; bus_addr = AW'(5); bus_wdata = W'($urandom);
      end else if (r == 8) begin
        bus_wr = 1'b1; bus_addr = AW'($urandom % 4); bus_wdata = W'($urandom);
      end else begin
        bus_addr = AW'(k % 7);
      end
      cyc();
    end
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    check("R11", int'(count), 0, "counter in reset");
    check("R11", int'(cap_flag), 0, "flags in reset");
    check("R11", int'(bus_rdata), 0, "reg A in reset");
    @(posedge clk); #2;
    rst_n = 1'b1;
    for (int a = 0; a < 7; a++) begin
      bus_addr = AW'(a);
      cyc();
    end

    // R1: counter runs, writes to it are ignored
    cur_req = "R1";
    wr(6, 16'hbeef);
    bus_addr = AW'(6);
    repeat (4) cyc();

    // R10: register access
    cur_req = "R10";
    for (int a = 0; a < 4; a++) wr(a, 16'h1111 * (a + 1));
    wr(4, 16'hffff);
    for (int a = 0; a < 8; a++) begin
      bus_addr = AW'(a);
      cyc();
    end

    // R2: independent channels, both polarity patterns
    cur_req = "R2";
    wr(4, 16'h0005);
    run_rand(400, 4'hf);
    wr(4, 16'h000a);
    run_rand(300, 4'hf);

    // R3 with R6: buffer on A/C, both select rising
    cur_req = "R3";
    wr(4, 16'h0015);
    run_rand(300, 4'hf);

    // R4 with R5: buffer on both pairs, selects differ in each pair
    cur_req = "R4";
    wr(4, 16'h0033);
    run_rand(300, 4'hf);
    cur_req = "R5";
    wr(4, 16'h003c);
    run_rand(300, 4'h3);

    // R6: equal selects, falling only on A and B
    cur_req = "R6";
    wr(4, 16'h0030);
    run_rand(300, 4'hf);

    // R7: only pins C and D move while both pairs are buffered
    cur_req = "R7";
    wr(4, 16'h0035);
    run_rand(300, 4'hc);

    // R8: flag arming and clearing
    cur_req = "R8";
    wr(4, 16'h0005);
    cap_pin = '0;
    repeat (5) cyc();
    rd_flags();
    wr(5, 0);
    check("R8", int'(cap_flag[0]), 0, "flag A after clear");
    cap_pin[0] = 1'b1;
    repeat (4) cyc();
    check("R8", int'(cap_flag[0]), 1, "flag A after rising edge");
    wr(5, 0);
    check("R8", int'(cap_flag[0]), 1, "flag A after unarmed write");
    rd_flags();
    wr(5, 16'h000f);
    check("R8", int'(cap_flag[0]), 1, "flag A after writing 1");
    rd_flags();
    wr(5, 0);
    check("R8", int'(cap_flag[0]), 0, "flag A after armed clear");

    // R9: write to A lands on the capture clock
    cur_req = "R9";
    cap_pin = '0;
    repeat (5) cyc();
    cap_pin[0] = 1'b1;
    cyc();
    cyc();
    bus_wr = 1'b1; bus_addr = AW'(0); bus_wdata = 16'h1234;
    cyc();
    bus_wr = 1'b0;
    check("R9", int'(bus_rdata == 16'h1234), 0, "reg A took write over capture");
    // R9 in buffer mode: write to C on the shift clock
    wr(4, 16'h0015);
    cap_pin = '0;
    repeat (5) cyc();
    cap_pin[0] = 1'b1;
    cyc();
    cyc();
    bus_wr = 1'b1; bus_addr = AW'(2); bus_wdata = 16'h4321;
    cyc();
    bus_wr = 1'b0;
    check("R9", int'(bus_rdata == 16'h4321), 0, "reg C took write over shift");
    repeat (3) cyc();

    summary();
    $finish;
  end

endmodule